// File: doc/BRIEF.md
# Ethernet Port Mode Resolver

This block decides how one switch port presents itself to its MAC: whether the link is up, the line speed, the duplex and whether 802.3x pause is in use. During reset it captures a set of strap inputs into shadow copies of the PHY control and advertisement registers. After reset those shadows can be rewritten through a small address/data write port, and a per-port enable bit can hide the link from the MAC.

Each cycle a resolution state machine picks one path from the shadows and the link partner inputs. ST_DOWN means no usable medium. ST_FIBER is forced 100 Mb/s fiber. ST_FORCED is twisted pair with negotiation disabled. ST_NEGOTIATED uses the shared abilities of both ends. ST_PARALLEL covers a partner that does not negotiate. ST_MII selects the secondary MII medium. The machine moves between states only through its next-state choice, which it evaluates in a fixed order:

1. The enable bit is clear: to ST_DOWN.
2. The media strap selects fiber and the line has link: to ST_FIBER.
3. Twisted pair has link and negotiation is off: to ST_FORCED.
4. Twisted pair has link and the partner does not negotiate: to ST_PARALLEL.
5. Twisted pair has link, the partner negotiates and at least one ability is shared: to ST_NEGOTIATED.
6. Otherwise, if the MII reports link: to ST_MII.
7. Otherwise: to ST_DOWN.

The state and the MAC-side outputs are registered from the same next-state choice.

Top module: `port_mode_resolver`

## Requirements
- R1: While rst_n is low, the block loads its shadows from the straps. Control shadows: auto-negotiation enable = strap_aneg, speed 100 = strap_spd100, full duplex = strap_full. Advertised abilities: 10 half = 1, 10 full = strap_full, 100 half = strap_spd100, 100 full = strap_spd100 AND strap_full, pause = strap_pause. The media type is strap_utp (1 twisted pair, 0 fiber). Strap changes after reset have no effect.
- R2: The write port has three registers, and a write with wr_en high updates the addressed one.
  - Address 0 holds the control shadows: bit 13 speed 100, bit 12 auto-negotiation enable, bit 8 full duplex.
  - Address 4 holds the advertisement: bit 5 10 half, bit 6 10 full, bit 7 100 half, bit 8 100 full, bit 10 pause.
  - Address 16 holds the enable, in bit 0. The enable resets to 1.
- R3: In fiber mode with link, the result is 100 Mb/s. The negotiation and speed shadows are ignored. Duplex is the full duplex shadow, and pause is that duplex AND the advertised pause.
- R4: When negotiation is enabled and the partner negotiates, the result is the highest shared ability. The order is 100 full, 100 half, 10 full, 10 half.
- R5: Pause is on only in full duplex. In ST_NEGOTIATED it also needs both the advertised pause and lp_pause.
- R6: If no ability is shared during negotiation, the twisted pair medium is not used. The port then falls back to the MII, or is down.
- R7: Parallel detection applies when negotiation is enabled and lp_neg=0. The speed is pd_speed100, the duplex is half and pause is off.
- R8: With negotiation disabled on twisted pair, speed and duplex follow the control shadows. Pause is full duplex AND the advertised pause.
- R9: When twisted pair is usable, it wins over the MII even if the MII has link, and mac_via_mii=0. When the MII is selected, speed and duplex come from mii_speed100 and mii_full, pause is mii_full AND mii_pause, and mac_via_mii=1.
- R10: With the enable at 0, mac_link and all other outputs are 0, whatever the link inputs are.
- R11: Outputs are registered. An input change sampled at a clock edge appears after that edge. A write sampled at edge k still gives the old result at edge k, and the new result at edge k+1.
- R12: While rst_n is low, all outputs are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are latched while low |
| strap_utp | input | 1 | Media strap: 1 twisted pair, 0 fiber |
| strap_aneg | input | 1 | Strap for auto-negotiation enable |
| strap_spd100 | input | 1 | Strap for speed 100 |
| strap_full | input | 1 | Strap for full duplex |
| strap_pause | input | 1 | Strap for pause advertisement |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address (0, 4 or 16) |
| wr_data | input | DATA_W | Register write data |
| utp_link | input | 1 | Line link status (twisted pair or fiber) |
| lp_neg | input | 1 | Partner performs auto-negotiation |
| lp_abil | input | 4 | Partner abilities: [0] 10H, [1] 10F, [2] 100H, [3] 100F |
| lp_pause | input | 1 | Partner advertises pause |
| pd_speed100 | input | 1 | Parallel detection found a 100 Mb/s signal |
| mii_link | input | 1 | MII medium link status |
| mii_speed100 | input | 1 | MII medium speed 100 |
| mii_full | input | 1 | MII medium full duplex |
| mii_pause | input | 1 | MII medium pause enable |
| mac_link | output | 1 | Link seen by the MAC |
| mac_speed100 | output | 1 | Resolved speed: 1 = 100 Mb/s |
| mac_full | output | 1 | Resolved full duplex |
| mac_pause | output | 1 | Resolved flow control |
| mac_via_mii | output | 1 | MII medium selected |

## Verification
Each resolution path leaves a distinct signature on the five MAC outputs. A wrong state therefore shows up one edge after the inputs that select it. For example, a wrong path shows a half-duplex result where full was due, or pause set in half duplex, or the MII flagged while twisted pair has link. A corrupted shadow register shows up only when a later stimulus reads that field. For that reason the bench checks the old result on the write edge and the new result on the edge after it.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    typedef enum logic [2:0] {
        ST_DOWN,
        ST_FIBER,
        ST_FORCED,
        ST_NEGOTIATED,
        ST_PARALLEL,
        ST_MII
    } res_state_t;

    // ability vector index: 0 10H, 1 10F, 2 100H, 3 100F (index order is priority)
    localparam int ABIL_N = 4;
    localparam int ABIL_IDX_W = $clog2(ABIL_N);

    // shadow field positions decoded from the write port
    localparam int CTL_SPD_BIT   = 13;
    localparam int CTL_ANEG_BIT  = 12;
    localparam int CTL_FULL_BIT  = 8;
    localparam int ADV_BASE_BIT  = 5;
    localparam int ADV_PAUSE_BIT = 10;
    localparam int EN_BIT        = 0;

    typedef struct packed {
        logic link;
        logic spd100;
        logic full;
        logic pause;
        logic via_mii;
    } mac_mode_t;

endpackage

// File: rtl/pmr_regs.sv
module pmr_regs
    import pmr_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 0,
    parameter int ADV_ADDR  = 4,
    parameter int EN_ADDR   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_utp,
    input  logic              strap_aneg,
    input  logic              strap_spd100,
    input  logic              strap_full,
    input  logic              strap_pause,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              utp_mode,
    output logic              aneg_en,
    output logic              force_spd100,
    output logic              force_full,
    output logic [ABIL_N-1:0] adv_abil,
    output logic              adv_pause,
    output logic              port_en
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_ADV  = ADDR_W'(ADV_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

    logic hit_ctrl, hit_adv, hit_en;
    assign hit_ctrl = wr_en && (wr_addr == A_CTRL);
    assign hit_adv  = wr_en && (wr_addr == A_ADV);
    assign hit_en   = wr_en && (wr_addr == A_EN);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            utp_mode     <= strap_utp;
            aneg_en      <= strap_aneg;
            force_spd100 <= strap_spd100;
            force_full   <= strap_full;
            adv_abil     <= {strap_spd100 & strap_full, strap_spd100, strap_full, 1'b1};
            adv_pause    <= strap_pause;
            port_en      <= 1'b1;
        end else begin
            if (hit_ctrl) begin
                aneg_en      <= wr_data[CTL_ANEG_BIT];
                force_spd100 <= wr_data[CTL_SPD_BIT];
                force_full   <= wr_data[CTL_FULL_BIT];
            end
            if (hit_adv) begin
                adv_abil  <= wr_data[ADV_BASE_BIT +: ABIL_N];
                adv_pause <= wr_data[ADV_PAUSE_BIT];
            end
            if (hit_en) begin
                port_en <= wr_data[EN_BIT];
            end
        end
    end

    AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |=> (aneg_en == $past(wr_data[CTL_ANEG_BIT]))
                  && (force_full == $past(wr_data[CTL_FULL_BIT]))); // R2
    AST_ADV_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_adv |=> (adv_abil == $past(wr_data[ADV_BASE_BIT +: ABIL_N]))); // R2
    AST_EN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en |=> (port_en == $past(wr_data[EN_BIT]))); // R2

endmodule

// File: rtl/pmr_pick.sv
module pmr_pick
    import pmr_pkg::*;
(
    input  logic [ABIL_N-1:0] common,
    output logic              valid,
    output logic              spd100,
    output logic              full
);

    logic [ABIL_IDX_W-1:0] best;

    // scan upward so the highest-priority shared ability is the last one kept
    always_comb begin
        valid = 1'b0;
        best  = '0;
        for (int i = 0; i < ABIL_N; i++) begin
            if (common[i]) begin
                valid = 1'b1;
                best  = ABIL_IDX_W'(i);
            end
        end
    end

    assign spd100 = best[1];
    assign full   = best[0];

endmodule

// File: rtl/port_mode_resolver.sv
module port_mode_resolver
    import pmr_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 0,
    parameter int ADV_ADDR  = 4,
    parameter int EN_ADDR   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_utp,
    input  logic              strap_aneg,
    input  logic              strap_spd100,
    input  logic              strap_full,
    input  logic              strap_pause,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              utp_link,
    input  logic              lp_neg,
    input  logic [3:0]        lp_abil,
    input  logic              lp_pause,
    input  logic              pd_speed100,
    input  logic              mii_link,
    input  logic              mii_speed100,
    input  logic              mii_full,
    input  logic              mii_pause,
    output logic              mac_link,
    output logic              mac_speed100,
    output logic              mac_full,
    output logic              mac_pause,
    output logic              mac_via_mii
);

    logic              utp_mode, aneg_en, force_spd100, force_full, adv_pause, port_en;
    logic [ABIL_N-1:0] adv_abil;
    logic [ABIL_N-1:0] common;
    logic              pick_valid, pick_spd100, pick_full;

    res_state_t state_q, state_d;
    mac_mode_t  mode_q;

    pmr_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_ADDR(CTRL_ADDR),
        .ADV_ADDR (ADV_ADDR),
        .EN_ADDR  (EN_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_utp   (strap_utp),
        .strap_aneg  (strap_aneg),
        .strap_spd100(strap_spd100),
        .strap_full  (strap_full),
        .strap_pause (strap_pause),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .utp_mode    (utp_mode),
        .aneg_en     (aneg_en),
        .force_spd100(force_spd100),
        .force_full  (force_full),
        .adv_abil    (adv_abil),
        .adv_pause   (adv_pause),
        .port_en     (port_en)
    );

    assign common = adv_abil & lp_abil;

    pmr_pick u_pick (
        .common(common),
        .valid (pick_valid),
        .spd100(pick_spd100),
        .full  (pick_full)
    );

    // next-state choice, evaluated in priority order
    always_comb begin
        state_d = ST_DOWN;
        if (!port_en) begin
            state_d = ST_DOWN;
        end else if (!utp_mode && utp_link) begin
            state_d = ST_FIBER;
        end else if (utp_mode && utp_link && !aneg_en) begin
            state_d = ST_FORCED;
        end else if (utp_mode && utp_link && !lp_neg) begin
            state_d = ST_PARALLEL;
        end else if (utp_mode && utp_link && pick_valid) begin
            state_d = ST_NEGOTIATED;
        end else if (mii_link) begin
            state_d = ST_MII;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DOWN;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            unique case (state_d)
                ST_DOWN:       mode_q <= '0;
                ST_FIBER:      mode_q <= '{link: 1'b1, spd100: 1'b1, full: force_full,
                                           pause: force_full & adv_pause, via_mii: 1'b0};
                ST_FORCED:     mode_q <= '{link: 1'b1, spd100: force_spd100, full: force_full,
                                           pause: force_full & adv_pause, via_mii: 1'b0};
                ST_NEGOTIATED: mode_q <= '{link: 1'b1, spd100: pick_spd100, full: pick_full,
                                           pause: pick_full & adv_pause & lp_pause, via_mii: 1'b0};
                ST_PARALLEL:   mode_q <= '{link: 1'b1, spd100: pd_speed100, full: 1'b0,
                                           pause: 1'b0, via_mii: 1'b0};
                ST_MII:        mode_q <= '{link: 1'b1, spd100: mii_speed100, full: mii_full,
                                           pause: mii_full & mii_pause, via_mii: 1'b1};
                default:       mode_q <= '0;
            endcase
        end
    end

    assign mac_link     = mode_q.link;
    assign mac_speed100 = mode_q.spd100;
    assign mac_full     = mode_q.full;
    assign mac_pause    = mode_q.pause;
    assign mac_via_mii  = mode_q.via_mii;

    AST_EN_HIDES_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !mac_link); // R10
    AST_HALF_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_full |-> !mac_pause); // R5
    AST_PARALLEL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARALLEL) |-> (!mac_full && mac_link)); // R7
    AST_FIBER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIBER) |-> (mac_speed100 && !mac_via_mii)); // R3
    AST_UTP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && utp_mode && utp_link && !aneg_en) |=> !mac_via_mii); // R9

endmodule

// File: tb/port_mode_resolver_test.sv
module port_mode_resolver_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        strap_utp = 1'b1, strap_aneg = 1'b1, strap_spd100 = 1'b1, strap_full = 1'b1, strap_pause = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        utp_link = 1'b0, lp_neg = 1'b0, lp_pause = 1'b0, pd_speed100 = 1'b0;
    logic [3:0]  lp_abil = '0;
    logic        mii_link = 1'b0, mii_speed100 = 1'b0, mii_full = 1'b0, mii_pause = 1'b0;
    logic        mac_link, mac_speed100, mac_full, mac_pause, mac_via_mii;

    port_mode_resolver uut (
        .clk(clk), .rst_n(rst_n),
        .strap_utp(strap_utp), .strap_aneg(strap_aneg), .strap_spd100(strap_spd100),
        .strap_full(strap_full), .strap_pause(strap_pause),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .utp_link(utp_link), .lp_neg(lp_neg), .lp_abil(lp_abil), .lp_pause(lp_pause),
        .pd_speed100(pd_speed100),
        .mii_link(mii_link), .mii_speed100(mii_speed100), .mii_full(mii_full), .mii_pause(mii_pause),
        .mac_link(mac_link), .mac_speed100(mac_speed100), .mac_full(mac_full),
        .mac_pause(mac_pause), .mac_via_mii(mac_via_mii)
    );

    // bench-side shadow of the register contents
    logic       m_utp, m_aneg, m_spd, m_full, m_advp, m_en;
    logic [3:0] m_adv;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [4:0] model();
        logic [3:0] c;
        logic       p;
        if (!m_en) return 5'b0;
        if (!m_utp) begin
            if (utp_link) return {1'b1, 1'b1, m_full, m_full & m_advp, 1'b0};
        end else if (utp_link) begin
            if (!m_aneg) return {1'b1, m_spd, m_full, m_full & m_advp, 1'b0};
            if (!lp_neg) return {1'b1, pd_speed100, 1'b0, 1'b0, 1'b0};
            c = m_adv & lp_abil;
            p = m_advp & lp_pause;
            if (c[3]) return {1'b1, 1'b1, 1'b1, p, 1'b0};
            if (c[2]) return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            if (c[1]) return {1'b1, 1'b0, 1'b1, p, 1'b0};
            if (c[0]) return {1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
        end
        if (mii_link) return {1'b1, mii_speed100, mii_full, mii_full & mii_pause, 1'b1};
        return 5'b0;
    endfunction

    function automatic logic [4:0] outs();
        return {mac_link, mac_speed100, mac_full, mac_pause, mac_via_mii};
    endfunction

    task automatic compare(input logic [4:0] exp, input string tag);
        n_cmp++;
        if (outs() !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (link,spd100,full,pause,mii)", tag, outs(), exp);
        end
    endtask

    // monitor: compare just after each active edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            compare(it.exp, it.tag);
        end
    end

    // driver: called at a negedge with inputs already set
    task automatic apply(input string tag);
        item_t it;
        it.exp = model();
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input string tag);
        item_t it;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        it.exp = model();
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 5'd0) begin m_spd = d[13]; m_aneg = d[12]; m_full = d[8]; end
        if (a == 5'd4) begin m_adv = d[8:5]; m_advp = d[10]; end
        if (a == 5'd16) m_en = d[0];
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        compare(5'b0, tag);
        m_utp = strap_utp; m_aneg = strap_aneg; m_spd = strap_spd100; m_full = strap_full;
        m_adv = {strap_spd100 & strap_full, strap_spd100, strap_full, 1'b1};
        m_advp = strap_pause; m_en = 1'b1;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset("R12 outputs zero in reset");
        utp_link = 1; lp_neg = 1; lp_abil = 4'b1111; lp_pause = 1;
        apply("R1 R4 all straps on gives 100 full pause");
        lp_abil = 4'b0010;
        apply("R4 partner 10 full with pause");
        lp_abil = 4'b0101;
        apply("R4 R5 100 half beats 10 half, no pause");
        lp_abil = 4'b0011; lp_pause = 0;
        apply("R5 partner without pause");
        lp_abil = 4'b0000;
        apply("R6 nothing shared, no MII, down");
        mii_link = 1; mii_speed100 = 0; mii_full = 1; mii_pause = 1;
        apply("R6 R9 nothing shared falls to MII");
        lp_neg = 0; pd_speed100 = 0;
        apply("R7 R9 parallel detect 10 half over MII");
        pd_speed100 = 1; lp_pause = 1;
        apply("R7 parallel detect 100 half");
        utp_link = 0;
        apply("R9 MII only");
        mii_full = 0;
        apply("R9 R5 MII half no pause");
        utp_link = 1; lp_neg = 1; lp_abil = 4'b1111;
        strap_full = 0; strap_aneg = 0; strap_spd100 = 0;
        apply("R1 strap change after reset ignored");
        wr(5'd0, 16'h0100, "R11 control write not yet visible");
        apply("R8 R2 forced 10 full with pause");
        wr(5'd4, 16'h0020, "R11 advert write not yet visible");
        apply("R8 forced pause needs advert pause");
        wr(5'd0, 16'h1000, "R11 negotiation re-enable pending");
        apply("R2 R4 only 10 half advertised");
        wr(5'd16, 16'h0000, "R11 enable clear pending");
        apply("R10 disabled port shows no link");
        utp_link = 0;
        apply("R10 disabled port hides MII link");
        wr(5'd16, 16'h0001, "R10 still disabled on write edge");
        apply("R10 re-enabled shows MII");
        // fiber personality
        strap_utp = 0; strap_aneg = 1; strap_spd100 = 0; strap_full = 0; strap_pause = 1;
        do_reset("R12 outputs zero in second reset");
        utp_link = 1; lp_neg = 1; lp_abil = 4'b0001;
        apply("R3 fiber 100 half ignoring speed strap");
        wr(5'd0, 16'h1100, "R11 fiber duplex write pending");
        apply("R3 fiber 100 full with pause");
        wr(5'd0, 16'h0000, "R3 fiber write edge");
        apply("R3 R5 fiber half drops pause");
        utp_link = 0; mii_link = 0;
        apply("R3 fiber no link down");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule